// File: doc/BRIEF.md
# Cascade Page Select and Next-Free Responder

This block is the per-device selection logic in a chain of memory devices. Each device holds a 16-bit page number and a 16-bit select value. The device counts as selected when the select value equals its page number, or when the select value is the broadcast code 16'hFFFF. Page numbers are handed out one device at a time. Only the device that is currently first non-full in the chain takes a page write. A mark-full command then passes setup on to the next device.

Each cycle the block also registers the address of the lowest empty local location, taken from a per-location valid vector. A full flag runs along the chain. A device drives its full output low when its full input is low and it has no room left, either because every location is valid or because setup marked it full. Only the one device with full input low and full output high answers next-free reads. On broadcast select, a page read is forced to zero unless the device is that responder, so at most one device drives data.

Top module: `chain_sel`

## Requirements
- R1: After hardware reset the page number is 16'h0000, the select value is 16'hFFFF, the mark-full state is cleared, and `rd_drive` and `rd_data` are zero.
- R2: A page write (op 3'd1) updates the page number only when `cmd_data` is not 16'hFFFF and the device is the responder (`full_in_n` low and `full_out_n` high). Otherwise it is ignored.
- R3: `selected` is high exactly when the select value equals the page number or the select value is 16'hFFFF. A select write (op 3'd2) is always accepted.
- R4: `full_out_n` is low exactly when `full_in_n` is low and the device is full. The device is full when every valid bit, as registered one cycle earlier, is set, or when the mark-full state is set.
- R5: A mark-full command (op 3'd3) sets the mark-full state only when the device is the responder. It has no effect otherwise.
- R6: The next-free address is the lowest index whose valid bit is 0, registered one cycle after `valid_vec`. It is 0 when no bit is 0.
- R7: A next-free read (op 3'd4) gives, on the next cycle, `rd_drive`=1 and `rd_data` = {page[4:0], zeros, next-free address in the low bits}, but only if the device is selected and is the responder. Otherwise `rd_drive`=0 and `rd_data`=0.
- R8: A page read (op 3'd5) gives, on the next cycle, `rd_drive`=1 and `rd_data`=page number if the device is selected and either the select value is not 16'hFFFF or the device is the responder. Otherwise both are 0.
- R9: A software reset (`soft_rst`) clears the mark-full state and the read outputs. It leaves the page number and the select value unchanged.
- R10: In any cycle after a cycle with no read command, `rd_drive` and `rd_data` are zero. Op 3'd0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| soft_rst | input | 1 | Software reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 16 | Command write data |
| valid_vec | input | DEPTH | Per-location occupied bits |
| full_in_n | input | 1 | Full flag from the previous device, active low |
| full_out_n | output | 1 | Full flag to the next device, active low |
| selected | output | 1 | Device selected |
| rd_drive | output | 1 | Device is driving read data |
| rd_data | output | 16 | Read data |

## Verification
The checker watches several rules on every cycle:
- a high full input always gives a high full output;
- the page number never holds 16'hFFFF;
- read data is zero whenever it is not driven, and nothing is driven after a cycle with no read;
- a driven next-free answer always comes from the responder;
- a software reset never moves the page number or the select value.

Other behaviour is shown only by the bench's scenarios. These are the next-free value for a given valid pattern, the rejection of page writes by a non-responder, the broadcast read restriction, and mark-full handing setup on to the next device.

// File: rtl/chain_sel.sv
module chain_sel #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_data,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic             full_in_n,
  output logic             full_out_n,
  output logic             selected,
  output logic             rd_drive,
  output logic [15:0]      rd_data
);
  localparam logic [2:0] OP_WPAGE = 3'd1;
  localparam logic [2:0] OP_WSEL  = 3'd2;
  localparam logic [2:0] OP_MARK  = 3'd3;
  localparam logic [2:0] OP_RNF   = 3'd4;
  localparam logic [2:0] OP_RPAGE = 3'd5;
  localparam logic [15:0] BCAST   = 16'hFFFF;

  logic [15:0]   pa_q, ds_q;
  logic [AW-1:0] nf_q, nf_enc;
  logic          all_valid_q, marked_q;
  logic          responder, bcast;
  logic [15:0]   nf_word;

  always_comb begin
    nf_enc = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid_vec[i]) nf_enc = AW'(i);
  end

  assign bcast      = (ds_q == BCAST);
  assign selected   = bcast || (ds_q == pa_q);
  assign full_out_n = !(!full_in_n && (all_valid_q || marked_q));
  assign responder  = !full_in_n && full_out_n;
  assign nf_word    = {pa_q[4:0], {(11 - AW){1'b0}}, nf_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_q        <= '0;
      all_valid_q <= 1'b0;
    end else begin
      nf_q        <= nf_enc;
      all_valid_q <= &valid_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 16'h0000;
      ds_q <= BCAST;
    end else if (cmd_valid) begin
      if (cmd_op == OP_WPAGE && responder && cmd_data != BCAST) pa_q <= cmd_data;
      if (cmd_op == OP_WSEL) ds_q <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) marked_q <= 1'b0;
    else if (soft_rst) marked_q <= 1'b0;
    else if (cmd_valid && cmd_op == OP_MARK && responder) marked_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_drive <= 1'b0;
      rd_data  <= '0;
      if (!soft_rst && cmd_valid) begin
        if (cmd_op == OP_RNF && selected && responder) begin
          rd_drive <= 1'b1;
          rd_data  <= nf_word;
        end else if (cmd_op == OP_RPAGE && selected && (!bcast || responder)) begin
          rd_drive <= 1'b1;
          rd_data  <= pa_q;
        end
      end
    end
  end
endmodule

// File: rtl/chain_sel_chk.sv
module chain_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        full_in_n,
  input logic        full_out_n,
  input logic        rd_drive,
  input logic [15:0] rd_data,
  input logic [15:0] pa_q,
  input logic [15:0] ds_q
);
  p_ff_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_in_n |-> full_out_n);

  p_page_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pa_q != 16'hFFFF);

  p_nodrive_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == 16'h0000);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rd_drive);

  p_nf_responder_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4 && !(!full_in_n && full_out_n)) |=> !rd_drive);

  p_soft_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !cmd_valid) |=> ($stable(pa_q) && $stable(ds_q)));
endmodule

bind chain_sel chain_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .full_in_n(full_in_n), .full_out_n(full_out_n),
  .rd_drive(rd_drive), .rd_data(rd_data), .pa_q(pa_q), .ds_q(ds_q)
);

// File: tb/chain_sel_tb_top.sv
`timescale 1ns/1ps
module chain_sel_tb_top;
  localparam int DEPTH = 16;
  logic clk = 0, rst_n = 0, soft_rst = 0, cmd_valid = 0, full_in_n = 0;
  logic [2:0] cmd_op = 0;
  logic [15:0] cmd_data = 0;
  logic [DEPTH-1:0] valid_vec = '0;
  logic full_out_n, selected, rd_drive;
  logic [15:0] rd_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  chain_sel #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .valid_vec(valid_vec),
    .full_in_n(full_in_n), .full_out_n(full_out_n), .selected(selected),
    .rd_drive(rd_drive), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic rd(input logic [2:0] op, input string req, input logic dv, input logic [15:0] dd);
    cmd(op, 16'h0);
    chk({req, " drive"}, rd_drive, dv);
    chk({req, " data"}, rd_data, dd);
  endtask

  task automatic t_reset;
    chk("R1 drive", rd_drive, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 sel", selected, 1);
    chk("R1 ff", full_out_n, 1);
    rd(3'd5, "R1 page", 1, 16'h0000);
    rd(3'd4, "R1 nf", 1, 16'h0000);
    @(negedge clk);
    chk("R10 idle drive", rd_drive, 0);
  endtask

  task automatic t_page;
    full_in_n = 0;
    cmd(3'd1, 16'h1234);
    rd(3'd5, "R2 accept", 1, 16'h1234);
    cmd(3'd1, 16'hFFFF);
    rd(3'd5, "R2 ffff ignored", 1, 16'h1234);
    full_in_n = 1;
    cmd(3'd1, 16'h5555);
    full_in_n = 0;
    rd(3'd5, "R2 nonresp ignored", 1, 16'h1234);
  endtask

  task automatic t_select;
    cmd(3'd2, 16'h1234);
    chk("R3 match", selected, 1);
    cmd(3'd2, 16'h1235);
    chk("R3 mismatch", selected, 0);
    rd(3'd5, "R8 unselected", 0, 16'h0);
    cmd(3'd2, 16'hFFFF);
    chk("R3 bcast", selected, 1);
  endtask

  task automatic t_full;
    valid_vec = '1;
    @(negedge clk); @(negedge clk);
    chk("R4 full low", full_out_n, 0);
    full_in_n = 1; #1;
    chk("R4 upstream open", full_out_n, 1);
    full_in_n = 0;
    valid_vec = 16'hFFF7;
    @(negedge clk); @(negedge clk);
    chk("R4 room", full_out_n, 1);
  endtask

  task automatic t_nf;
    valid_vec = 16'h0007;
    @(negedge clk); @(negedge clk);
    rd(3'd4, "R6 R7 nf3", 1, 16'hA003);
    valid_vec = 16'hFFFE;
    @(negedge clk); @(negedge clk);
    rd(3'd4, "R6 nf0", 1, 16'hA000);
    valid_vec = 16'h7FFF;
    @(negedge clk); @(negedge clk);
    rd(3'd4, "R6 nf15", 1, 16'hA00F);
    full_in_n = 1;
    rd(3'd4, "R7 nonresp", 0, 16'h0);
    full_in_n = 0;
    valid_vec = '0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_bcast;
    full_in_n = 1;
    rd(3'd5, "R8 bcast nonresp", 0, 16'h0);
    cmd(3'd2, 16'h1234);
    rd(3'd5, "R8 direct", 1, 16'h1234);
    cmd(3'd2, 16'hFFFF);
    full_in_n = 0;
    rd(3'd5, "R8 bcast resp", 1, 16'h1234);
  endtask

  task automatic t_mark;
    full_in_n = 1;
    cmd(3'd3, 16'h0);
    full_in_n = 0; #1;
    chk("R5 ignored", full_out_n, 1);
    cmd(3'd3, 16'h0);
    chk("R5 marked", full_out_n, 0);
    cmd(3'd1, 16'h0042);
    cmd(3'd2, 16'h1234);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk("R9 unmarked", full_out_n, 1);
    chk("R9 ds kept", selected, 1);
    cmd(3'd2, 16'hFFFF);
    rd(3'd5, "R9 pa kept", 1, 16'h1234);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_page; t_select; t_full; t_nf; t_bcast; t_mark;
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule